// File: doc/BRIEF.md
# Serial Switch-Array Update Controller

This block sits on the host side of a chain of serially loaded 8-channel switch control registers. A parallel word holding every switch setting of the chain is presented together with a one-cycle start strobe. The controller then shifts the whole word out on a serial data pin, using a serial clock that it derives from the system clock.

Throughout the shift the latch-enable pin is held high, so the switch outputs never show a partial pattern. After the last bit has been clocked, the controller waits a programmable setup interval. It then drives latch-enable low for a programmable pulse width and returns it high, which transfers the new pattern to all switches at once. Finally it raises a one-cycle done flag.

The number of chained devices, the serial clock half-period, the setup delay and the latch pulse width are all parameters counted in system clock cycles. This lets the serial clock be kept under the receiver's frequency limit and lets the latch margins be met at any supply voltage.

Top module: `swarr_loader`

## Requirements
- R1: While reset is asserted and directly after it, `ser_clk` is 0, `latch_n` is 1 and `done` is 0.
- R2: The word is sent most significant bit first: bit `NDEV*8-1` first and bit 0 last. The byte for the farthest device, bits `[NDEV*8-1 -: 8]`, goes first. Within each byte the switch-7 bit goes first, so that after the latch a receiving chain holds exactly `settings`.
- R3: Each transfer has exactly `NDEV*8` rising edges on `ser_clk`. Each serial clock phase lasts `HALF_CYC` system cycles. The first rising edge comes `HALF_CYC` cycles after the cycle in which start is sampled.
- R4: `ser_data` changes only while `ser_clk` is low. It is stable during every high phase of `ser_clk`.
- R5: `latch_n` stays high for the whole shift. No rising edge of `ser_clk` occurs while `latch_n` is low.
- R6: `latch_n` falls exactly `SETUP_CYC` cycles after the last falling edge of `ser_clk`. It then stays low for exactly `PULSE_CYC` cycles.
- R7: `done` is high for exactly one cycle. It rises one cycle after `latch_n` returns high, which is `2*NDEV*8*HALF_CYC + SETUP_CYC + PULSE_CYC + 1` cycles after start is sampled.
- R8: A start strobe seen during a transfer is ignored. The word being sent, the output timing and the latched result are those of the original start.
- R9: Each of `NDEV`, `HALF_CYC`, `SETUP_CYC` and `PULSE_CYC` below 1 is rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to load `settings` into the chain |
| settings | input | NDEV*8 | Switch settings of the whole chain, farthest device in the top byte |
| ser_clk | output | 1 | Serial clock; receivers sample on its rising edge |
| ser_data | output | 1 | Serial data |
| latch_n | output | 1 | Latch enable: high holds the outputs, a low pulse transfers the pattern |
| done | output | 1 | One-cycle pulse when the new pattern has been latched |

## Verification
The bench builds the controller with two chained devices, a two-cycle serial clock half-period, a three-cycle setup delay and a two-cycle latch pulse. This keeps each transfer near seventy cycles, so many transfers fit in one run.

These settings make every 16-bit pattern class cheap to apply: all zeros, all ones, every walking one and every walking zero, plus a set of pseudo-random words. A behavioural model of the receiving chain checks the bit order of both bytes. The small, distinct delays make an off-by-one in the clock phase, the setup wait or the pulse width visible as a cycle-count miscompare.

// File: rtl/swarr_pkg.sv
package swarr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SHIFT  = 3'd1,
      ST_SETUP  = 3'd2,
      ST_LOW    = 3'd3,
      ST_HIGH   = 3'd4,
      ST_DONE   = 3'd5
   } swarr_state_e;
endpackage

// File: rtl/swarr_timer.sv
module swarr_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/swarr_serializer.sv
module swarr_serializer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] word,
   output logic         bit_out
);
   logic [W-1:0] sr_q;

   generate
      if (W == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)
               sr_q <= '0;
            else if (load)
               sr_q <= word;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n)
               sr_q <= '0;
            else if (load)
               sr_q <= word;
            else if (shift)
               sr_q <= {sr_q[W-2:0], 1'b0};
         end
      end
   endgenerate

   assign bit_out = sr_q[W-1];
endmodule

// File: rtl/swarr_loader.sv
module swarr_loader
   import swarr_pkg::*;
#(
   parameter int NDEV      = 2,
   parameter int HALF_CYC  = 2,
   parameter int SETUP_CYC = 3,
   parameter int PULSE_CYC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NDEV*8-1:0]  settings,
   output logic               ser_clk,
   output logic               ser_data,
   output logic               latch_n,
   output logic               done
);
   localparam int NBITS = NDEV * 8;
   localparam int MAXC  = (HALF_CYC > SETUP_CYC) ?
                          ((HALF_CYC > PULSE_CYC) ? HALF_CYC : PULSE_CYC) :
                          ((SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC);
   localparam int TW    = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam int BW    = (NBITS < 2) ? 1 : $clog2(NBITS);
   localparam logic [TW-1:0] HALF_LD  = TW'(HALF_CYC - 1);
   localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
   localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYC - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

   // R9: parameter legality at elaboration
   generate
      if (NDEV < 1) begin : g_bad_ndev
         $error("swarr_loader: NDEV must be at least 1");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("swarr_loader: HALF_CYC must be at least 1");
      end
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("swarr_loader: SETUP_CYC must be at least 1");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("swarr_loader: PULSE_CYC must be at least 1");
      end
   endgenerate

   swarr_state_e  state_q;
   logic          sclk_q;
   logic          latch_q;
   logic [BW-1:0] bit_q;
   logic          tm_load;
   logic [TW-1:0] tm_val;
   logic          tm_exp;
   logic          sr_load;
   logic          sr_shift;
   logic          last_bit;

   assign last_bit = (bit_q == LAST_BIT);
   assign sr_load  = (state_q == ST_IDLE) && start;
   assign sr_shift = (state_q == ST_SHIFT) && tm_exp && sclk_q && !last_bit;

   always_comb begin
      tm_load = 1'b0;
      tm_val  = HALF_LD;
      case (state_q)
         ST_IDLE: begin
            tm_load = start;
            tm_val  = HALF_LD;
         end
         ST_SHIFT: begin
            tm_load = tm_exp;
            tm_val  = (sclk_q && last_bit) ? SETUP_LD : HALF_LD;
         end
         ST_SETUP: begin
            tm_load = tm_exp;
            tm_val  = PULSE_LD;
         end
         default: begin
            tm_load = 1'b0;
            tm_val  = HALF_LD;
         end
      endcase
   end

   swarr_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .expired  (tm_exp)
   );

   swarr_serializer #(.W(NBITS)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sr_load),
      .shift   (sr_shift),
      .word    (settings),
      .bit_out (ser_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sclk_q  <= 1'b0;
         latch_q <= 1'b1;
         bit_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_SHIFT;
                  sclk_q  <= 1'b0;
                  bit_q   <= '0;
               end
            end
            ST_SHIFT: begin
               if (tm_exp) begin
                  sclk_q <= !sclk_q;
                  if (sclk_q) begin
                     if (last_bit)
                        state_q <= ST_SETUP;
                     else
                        bit_q <= bit_q + 1'b1;
                  end
               end
            end
            ST_SETUP: begin
               if (tm_exp) begin
                  latch_q <= 1'b0;
                  state_q <= ST_LOW;
               end
            end
            ST_LOW: begin
               if (tm_exp) begin
                  latch_q <= 1'b1;
                  state_q <= ST_HIGH;
               end
            end
            ST_HIGH: state_q <= ST_DONE;
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ser_clk = sclk_q;
   assign latch_n = latch_q;
   assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/swarr_loader_chk.sv
module swarr_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic ser_clk,
   input logic ser_data,
   input logic latch_n,
   input logic done
);
   // R5: serial clock never rises while the latch is open
   assert_clk_rise_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> latch_n);

   // R4: data is held through a high phase of the serial clock
   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   // R7: done lasts a single cycle
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: done only after the latch has closed again
   assert_done_after_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (latch_n && $past(latch_n)));

   // R6: the latch opens only with the serial clock parked low
   assert_latch_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_n) |-> (!ser_clk && $past(!ser_clk)));

   // R1: no serial activity or done in the first cycle after reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      (rst_n && !$past(rst_n)) |-> (!ser_clk && latch_n && !done));
endmodule

bind swarr_loader swarr_loader_chk u_swarr_loader_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .ser_clk  (ser_clk),
   .ser_data (ser_data),
   .latch_n  (latch_n),
   .done     (done)
);

// File: tb/swarr_loader_bench.sv
`timescale 1ns/1ps
module swarr_loader_bench;
   localparam int NDEV  = 2;
   localparam int HALF  = 2;
   localparam int SETUP = 3;
   localparam int PULSE = 2;
   localparam int NB    = NDEV * 8;
   localparam int XFER  = 2 * NB * HALF + SETUP + PULSE + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NB-1:0] settings = '0;
   logic          ser_clk, ser_data, latch_n, done;

   int vectors = 0;
   int errors  = 0;
   int cyc     = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   swarr_loader #(.NDEV(NDEV), .HALF_CYC(HALF), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE)) u_swarr_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .settings(settings),
      .ser_clk(ser_clk), .ser_data(ser_data), .latch_n(latch_n), .done(done)
   );

   // Receiving chain model and timing monitors, sampled at the falling system edge
   logic [NB-1:0] chain = '0;
   logic [NB-1:0] held  = '0;
   logic p_clk = 1'b0, p_data = 1'b0, p_latch = 1'b1;
   int rises = 0, low_w = 0, last_low_w = 0, t_fall = 0, setup_seen = -1;
   int hold_viol = 0, open_rise = 0, hi_w = 0, bad_phase = 0, first_rise = -1;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_clk <= ser_clk; p_data <= ser_data; p_latch <= latch_n;
      end else begin
         if (!p_clk && ser_clk) begin
            chain <= {chain[NB-2:0], ser_data};
            rises <= rises + 1;
            if (first_rise < 0) first_rise <= cyc;
            if (!latch_n) open_rise <= open_rise + 1;
         end
         if (p_clk && ser_clk && (ser_data != p_data)) hold_viol <= hold_viol + 1;
         if (ser_clk) hi_w <= (p_clk ? hi_w + 1 : 1);
         if (p_clk && !ser_clk) begin
            t_fall <= cyc;
            if (hi_w != HALF) bad_phase <= bad_phase + 1;
         end
         if (p_latch && !latch_n) setup_seen <= cyc - t_fall;
         if (!latch_n) begin
            held  <= chain;
            low_w <= p_latch ? 1 : low_w + 1;
         end
         if (!p_latch && latch_n) last_low_w <= low_w;
         p_clk <= ser_clk; p_data <= ser_data; p_latch <= latch_n;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [NB-1:0] word, input bit poke);
      int t0;
      int wait_n;
      @(negedge clk);
      settings = word; start = 1'b1;
      rises = 0; first_rise = -1; bad_phase = 0;
      @(negedge clk);
      start = 1'b0; t0 = cyc;
      if (poke) begin
         repeat (9) @(negedge clk);
         settings = ~word; start = 1'b1;   // R8: must be ignored
         @(negedge clk);
         start = 1'b0;
      end
      wait_n = 0;
      while (!done && wait_n < 1000) begin
         @(negedge clk);
         wait_n++;
      end
      check(done == 1'b1 && (cyc - t0) == XFER, "R7 latency", cyc - t0, XFER);
      check(held == word, poke ? "R8 busy start ignored" : "R2 bit order", held, word);
      check(rises == NB, "R3 clock count", rises, NB);
      check(first_rise - t0 == HALF && bad_phase == 0, "R3 clock phase", first_rise - t0, HALF);
      check(last_low_w == PULSE, "R6 pulse width", last_low_w, PULSE);
      check(setup_seen == SETUP, "R6 setup delay", setup_seen, SETUP);
      check(hold_viol == 0, "R4 data hold", hold_viol, 0);
      check(open_rise == 0, "R5 latch closed during shift", open_rise, 0);
      @(negedge clk);
      check(done == 1'b0, "R7 done single", done, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++; vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [NB-1:0] lfsr;
      repeat (4) @(negedge clk);
      check(ser_clk == 0 && latch_n == 1 && done == 0, "R1 in reset", {ser_clk, latch_n, done}, 3'b010);
      rst_n = 1'b1;
      @(negedge clk);
      check(ser_clk == 0 && latch_n == 1 && done == 0, "R1 after reset", {ser_clk, latch_n, done}, 3'b010);
      run('0, 1'b0);
      run('1, 1'b0);
      for (int i = 0; i < NB; i++) run(NB'(1) << i, 1'b0);
      for (int i = 0; i < NB; i++) run(~(NB'(1) << i), 1'b0);
      lfsr = 16'hACE1;
      for (int i = 0; i < 12; i++) begin
         lfsr = {lfsr[NB-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         run(lfsr, i[0]);
      end
      run(16'hA55A, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule